// File: doc/BRIEF.md
# DAC Holding Register Controller

This block is the digital front end of a single-channel 12-bit digital-to-analog converter. A bus write arrives with a format select that gives one of three alignments: an 8-bit value right-aligned in the bus word, a 12-bit value left-aligned, or a 12-bit value right-aligned. The block normalises the value into a 12-bit holding register. It then moves the holding value into the output register that drives the converter. Software cannot write the output register.

The move from holding to output happens in one of two ways. With triggering disabled, a valid write reaches the output one clock after the holding register takes it. With triggering enabled, the output waits for a trigger event from the selected source. The source is either a self-clearing software trigger bit or an external event line. The external line is synchronised and edge-detected. At the trigger event the block captures the holding value, and it drives that value onto the output three clocks later. A trigger that arrives while a transfer is still in flight is dropped.

Top module: `dac_hold_ctrl`

## Requirements
- R1: A write with format select 0 (8-bit right-aligned) loads holding bits [11:4] from data bits [7:0] and clears holding bits [3:0].
- R2: A write with format select 1 (12-bit left-aligned) loads holding bits [11:0] from data bits [15:4].
- R3: A write with format select 2 (12-bit right-aligned) loads holding bits [11:0] from data bits [11:0].
- R4: A write with format select 3 is reserved. It changes neither the holding register nor the output, and it starts no transfer.
- R5: With trigger enable low at the write edge, the output shows the new holding value from the next clock edge onward. This holds for back-to-back writes.
- R6: With trigger enable high, writes alone never change the output.
- R7: With trigger enable high and trigger select 0 (software), a software trigger pulse sets the software trigger bit at the pulse edge. The trigger event occurs at the following edge, and the output updates on the third edge after the event.
- R8: The software trigger bit reads back as 1 from the edge after the pulse. It clears on the same edge on which the transfer reaches the output.
- R9: With trigger enable high and trigger select 1 (external), a rising edge on the external line passes two synchroniser flops and an edge detector. The output updates five edges after the first edge that samples the line high.
- R10: A trigger event that arrives while a transfer is pending is ignored.
- R11: The transfer carries the holding value present at the trigger event. Writes during the latency wait for the next trigger.
- R12: Reset clears the holding register, the output, the software trigger bit and any pending transfer.
- R13: A trigger from the unselected source, or any trigger while trigger enable is low, moves nothing to the output. A software trigger bit that is set waits until its source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_sel_i | input | 2 | Format select: 0 8-bit right, 1 12-bit left, 2 12-bit right, 3 reserved |
| wr_data_i | input | 16 | Write data word |
| trig_en_i | input | 1 | Trigger enable; 0 selects automatic transfer |
| trig_sel_i | input | 1 | Trigger source: 0 software, 1 external |
| sw_trig_i | input | 1 | Write pulse that sets the software trigger bit |
| ext_trig_i | input | 1 | Asynchronous external trigger line |
| dout_o | output | 12 | Output register value |
| sw_trig_o | output | 1 | Software trigger bit readback |

## Verification
The bench steers into the latency corners. It rewrites the holding register inside the three-cycle window, which shows whether the design captures at the trigger or at the transfer: a wrong design outputs the later value early. It sends a second external edge while a transfer is pending and then loads a new holding value. A design that accepts that edge pushes the new value out late. It also sets the software trigger while the external source is selected, which catches a design that fires from the wrong source or loses the held bit. Back-to-back automatic writes and reserved-format writes expose an off-by-one transfer delay and a holding register that corrupts on a bad select.

// File: rtl/dac_hold_pkg.sv
package dac_hold_pkg;
  typedef enum logic [1:0] {
    FMT_R8  = 2'd0,
    FMT_L12 = 2'd1,
    FMT_R12 = 2'd2,
    FMT_RSV = 2'd3
  } wr_fmt_e;

  typedef enum logic {
    SRC_SW  = 1'b0,
    SRC_EXT = 1'b1
  } trig_src_e;
endpackage

// File: rtl/dac_align.sv
module dac_align #(
  parameter int DW = 12,
  parameter int BW = 16,
  parameter int NW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [BW-1:0] wr_data_i,
  output logic [DW-1:0] hold_o,
  output logic          wr_ok_o
);
  import dac_hold_pkg::*;

  localparam int PAD = DW - NW;

  logic [DW-1:0] hold_q, aligned;
  logic          fmt_ok;

  always_comb begin
    fmt_ok  = 1'b1;
    aligned = hold_q;
    unique case (wr_sel_i)
      FMT_R8:  aligned = {wr_data_i[NW-1:0], {PAD{1'b0}}};
      FMT_L12: aligned = wr_data_i[BW-1 -: DW];
      FMT_R12: aligned = wr_data_i[DW-1:0];
      default: fmt_ok  = 1'b0;
    endcase
  end

  assign wr_ok_o = wr_en_i & fmt_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= '0;
    else if (wr_ok_o) hold_q <= aligned;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/dac_trig_sync.sv
module dac_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  // STAGES must be at least 2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ext_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dac_xfer_ctrl.sv
module dac_xfer_ctrl #(
  parameter int DW  = 12,
  parameter int LAT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] hold_i,
  input  logic          wr_ok_i,
  input  logic          trig_en_i,
  input  logic          trig_sel_i,
  input  logic          sw_set_i,
  input  logic          ext_rise_i,
  output logic [DW-1:0] dout_o,
  output logic          sw_bit_o,
  output logic          pend_o,
  output logic          done_o,
  output logic          auto_o,
  output logic [DW-1:0] latch_o
);
  import dac_hold_pkg::*;

  localparam int            CW   = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic [DW-1:0] dout_q, latch_q;
  logic [CW-1:0] cnt_q;
  logic          pend_q, sw_q, auto_q;
  logic          src_hit, evt, done;

  assign src_hit = (trig_sel_i == SRC_SW) ? sw_q : ext_rise_i;
  assign evt     = trig_en_i & ~pend_q & src_hit;
  assign done    = pend_q & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q  <= '0;
      latch_q <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      sw_q    <= 1'b0;
      auto_q  <= 1'b0;
    end else begin
      auto_q <= wr_ok_i & ~trig_en_i;

      if (auto_q)    dout_q <= hold_i;
      else if (done) dout_q <= latch_q;

      if (done)          sw_q <= 1'b0;
      else if (sw_set_i) sw_q <= 1'b1;

      if (evt) begin
        pend_q  <= 1'b1;
        cnt_q   <= '0;
        latch_q <= hold_i;
      end else if (done) begin
        pend_q <= 1'b0;
      end else if (pend_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign dout_o   = dout_q;
  assign sw_bit_o = sw_q;
  assign pend_o   = pend_q;
  assign done_o   = done;
  assign auto_o   = auto_q;
  assign latch_o  = latch_q;
endmodule

// File: rtl/dac_hold_ctrl.sv
module dac_hold_ctrl #(
  parameter int DW          = 12,
  parameter int BW          = 16,
  parameter int NW          = 8,
  parameter int TRIG_LAT    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [BW-1:0] wr_data_i,
  input  logic          trig_en_i,
  input  logic          trig_sel_i,
  input  logic          sw_trig_i,
  input  logic          ext_trig_i,
  output logic [DW-1:0] dout_o,
  output logic          sw_trig_o
);
  logic [DW-1:0] hold_q, latch_q;
  logic          wr_ok, ext_rise, xfer_pend, xfer_done, auto_q;

  dac_align #(.DW(DW), .BW(BW), .NW(NW)) u_align (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .hold_o (hold_q),
    .wr_ok_o(wr_ok)
  );

  dac_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .ext_i (ext_trig_i),
    .rise_o(ext_rise)
  );

  dac_xfer_ctrl #(.DW(DW), .LAT(TRIG_LAT)) u_xfer (
    .clk_i, .rst_ni,
    .hold_i    (hold_q),
    .wr_ok_i   (wr_ok),
    .trig_en_i,
    .trig_sel_i,
    .sw_set_i  (sw_trig_i),
    .ext_rise_i(ext_rise),
    .dout_o,
    .sw_bit_o  (sw_trig_o),
    .pend_o    (xfer_pend),
    .done_o    (xfer_done),
    .auto_o    (auto_q),
    .latch_o   (latch_q)
  );
endmodule

// File: rtl/dac_hold_ctrl_chk.sv
module dac_hold_ctrl_chk #(
  parameter int DW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [1:0]    wr_sel_i,
  input logic          trig_en_i,
  input logic          wr_ok,
  input logic [DW-1:0] hold_q,
  input logic [DW-1:0] latch_q,
  input logic          xfer_pend,
  input logic          xfer_done,
  input logic          auto_q,
  input logic [DW-1:0] dout_o,
  input logic          sw_trig_o
);
  always @(posedge clk_i)
    if (!rst_ni)
      assert_reset_clear_R12: assert (dout_o == '0 && !sw_trig_o && !xfer_pend);

  assert_rsv_no_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd3) |=> $stable(hold_q));

  assert_auto_one_clk_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && !trig_en_i) |=> ##1 (dout_o == $past(hold_q)));

  assert_out_only_on_xfer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dout_o) |-> $past(auto_q || xfer_done));

  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done |-> $past(xfer_pend, 2));

  assert_sw_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_trig_o) |-> $past(xfer_done));

  assert_carry_latch_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done && !auto_q) |=> (dout_o == $past(latch_q)));
endmodule

bind dac_hold_ctrl dac_hold_ctrl_chk #(.DW(DW)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .trig_en_i,
  .wr_ok, .hold_q, .latch_q, .xfer_pend, .xfer_done, .auto_q,
  .dout_o, .sw_trig_o
);

// File: tb/sim_dac_hold_ctrl.sv
`timescale 1ns/1ps
module sim_dac_hold_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd0;
  logic [15:0] wr_data_i = 16'h0;
  logic        trig_en_i = 1'b0;
  logic        trig_sel_i = 1'b0;
  logic        sw_trig_i = 1'b0;
  logic        ext_trig_i = 1'b0;
  logic [11:0] dout_o;
  logic        sw_trig_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    ended = 0;
  string cur_req = "R12";

  always #10 clk_i = ~clk_i;

  dac_hold_ctrl u0 (.*);

  // behavioural reference
  logic [11:0] m_hold, m_dout;
  bit          m_sw, m_auto;
  bit [2:0]    e_hist;
  int          cyc;
  int          due_q[$];
  logic [11:0] val_q[$];

  always @(posedge clk_i or negedge rst_ni) begin
    logic [11:0] oh;
    bit rise, pend, done, evt;
    if (!rst_ni) begin
      m_hold = '0; m_dout = '0; m_sw = 0; m_auto = 0; e_hist = '0; cyc = 0;
      due_q.delete(); val_q.delete();
    end else begin
      oh   = m_hold;
      rise = e_hist[1] & ~e_hist[2];
      pend = due_q.size() > 0;
      done = pend && due_q[0] == cyc;
      evt  = trig_en_i && !pend && (trig_sel_i ? rise : m_sw);
      if (m_auto)    m_dout = oh;
      else if (done) m_dout = val_q[0];
      if (done)           m_sw = 0;
      else if (sw_trig_i) m_sw = 1;
      if (wr_en_i)
        case (wr_sel_i)
          2'd0:    m_hold = {wr_data_i[7:0], 4'h0};
          2'd1:    m_hold = wr_data_i[15:4];
          2'd2:    m_hold = wr_data_i[11:0];
          default: ;
        endcase
      m_auto = wr_en_i && wr_sel_i != 2'd3 && !trig_en_i;
      if (done) begin void'(due_q.pop_front()); void'(val_q.pop_front()); end
      if (evt) begin due_q.push_back(cyc + 3); val_q.push_back(oh); end
      e_hist = {e_hist[1:0], ext_trig_i};
      cyc++;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni === 1'b1 && !ended) begin
      n_cmp++;
      if (dout_o !== m_dout || sw_trig_o !== m_sw) begin
        n_bad++;
        $display("FAIL %s per-cycle: dout=%h sw=%b expected dout=%h sw=%b",
                 cur_req, dout_o, sw_trig_o, m_dout, m_sw);
      end
    end
  end

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    wr_en_i = 1'b1; wr_sel_i = s; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic sw_pulse();
    sw_trig_i = 1'b1;
    @(negedge clk_i);
    sw_trig_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    idle(3);
    chk("R12", dout_o, 12'h000);
    chk("R12", {11'h0, sw_trig_o}, 12'h000);
    rst_ni = 1'b1;
    idle(1);

    cur_req = "R1";
    wr(2'd0, 16'h00AB); idle(1); chk("R1", dout_o, 12'hAB0);
    cur_req = "R2";
    wr(2'd1, 16'hABCD); idle(1); chk("R2", dout_o, 12'hABC);
    cur_req = "R3";
    wr(2'd2, 16'hF123); idle(1); chk("R3", dout_o, 12'h123);
    cur_req = "R4";
    wr(2'd3, 16'h0555); idle(3); chk("R4", dout_o, 12'h123);
    cur_req = "R5";
    wr(2'd2, 16'h00AA); wr(2'd2, 16'h00BB);
    chk("R5", dout_o, 12'h0AA);
    idle(1); chk("R5", dout_o, 12'h0BB);

    cur_req = "R6";
    trig_en_i = 1'b1; trig_sel_i = 1'b0;
    wr(2'd2, 16'h0456); idle(5); chk("R6", dout_o, 12'h0BB);

    cur_req = "R7";
    sw_pulse();
    chk("R8", {11'h0, sw_trig_o}, 12'h001);
    idle(3); chk("R7", dout_o, 12'h0BB);
    idle(1); chk("R7", dout_o, 12'h456);
    chk("R8", {11'h0, sw_trig_o}, 12'h000);

    cur_req = "R11";
    wr(2'd2, 16'h0111);
    sw_pulse(); idle(1);
    wr(2'd2, 16'h0222);
    idle(2); chk("R11", dout_o, 12'h111);
    sw_pulse(); idle(4); chk("R11", dout_o, 12'h222);

    cur_req = "R13";
    trig_sel_i = 1'b1;
    wr(2'd2, 16'h05A5);
    sw_pulse(); idle(6);
    chk("R13", dout_o, 12'h222);
    chk("R13", {11'h0, sw_trig_o}, 12'h001);
    trig_sel_i = 1'b0;
    idle(4); chk("R13", dout_o, 12'h5A5);

    cur_req = "R9";
    trig_sel_i = 1'b1;
    wr(2'd2, 16'h0333);
    ext_trig_i = 1'b1; idle(1);
    ext_trig_i = 1'b0; idle(1);
    ext_trig_i = 1'b1; idle(1);
    cur_req = "R10";
    wr(2'd2, 16'h0444);
    idle(1); chk("R9", dout_o, 12'h5A5);
    idle(1); chk("R9", dout_o, 12'h333);
    idle(4); chk("R10", dout_o, 12'h333);
    ext_trig_i = 1'b0;
    idle(2);

    cur_req = "R13";
    trig_en_i = 1'b0;
    ext_trig_i = 1'b1; idle(8);
    chk("R13", dout_o, 12'h333);
    ext_trig_i = 1'b0; idle(2);

    cur_req = "R12";
    trig_en_i = 1'b1; trig_sel_i = 1'b0;
    sw_pulse(); idle(1);
    rst_ni = 1'b0; idle(2);
    chk("R12", dout_o, 12'h000);
    chk("R12", {11'h0, sw_trig_o}, 12'h000);
    rst_ni = 1'b1; idle(6);
    chk("R12", dout_o, 12'h000);

    idle(2);
    finish_run();
  end
endmodule